// File: doc/BRIEF.md
# Increment-and-Skip Instruction Executor

This block executes two single-word 16-bit instructions of a small accumulator-style processor. Both read one byte from banked data memory, add one to it and send the result either to the working register (W) or back to the same memory location. One of them then skips the following instruction when the result is zero; the other skips it when the result is nonzero. A skip discards the instruction that has already been fetched and runs empty machine cycles in its place: one cycle when that instruction is one word long, two when it is two words long.

Each machine cycle has four phases, one clock each: decode, register read, compute and destination write. The executor accepts a word on `instr_valid` while it is idle, and it latches the bank-select value and the second-word flag in that same decode clock. The data address is 12 bits wide. The access bit chooses between the bank-select register and a fixed access bank: the low half of the 8-bit field maps to bank 0 and the high half maps to bank 15. `busy` stays high from the read phase to the end of any flush, so the fetch logic stalls. `squash` marks the clock in which the prefetched word is thrown away. No status flag exists and none is changed.

The controller has five states. ST_Q1_DECODE is idle and decode. ST_Q2_READ issues the memory read. ST_Q3_CALC captures the incremented value. ST_Q4_WRITE writes the destination and evaluates the skip. ST_NOP_FLUSH runs the empty phases. The transitions are: Q1 to Q2 on a legal valid word; Q2 to Q3 and Q3 to Q4 unconditionally; Q4 to Q1 when there is no skip; Q4 to NOP when there is a skip; and NOP to Q1 after the last empty cycle.

Top module: `incskip_exec`

## Requirements
- R1: A word is accepted only when `instr_valid` is high in ST_Q1_DECODE and bits [15:10] are 6'b001111 (skip-if-zero) or 6'b010010 (skip-if-nonzero). Bit 9 is the destination bit d, bit 8 is the bank bit a, and bits [7:0] are the field f. Any other word leaves `busy` low and issues no memory access.
- R2: With d=0 the result is written to W and memory is not written. With d=1 the result is written to memory at the read address and W keeps its value. W changes only while `busy` is high.
- R3: With a=1 the 12-bit address is {bsr, f}. With a=0 it is {4'h0, f} for f below 8'h80 and {4'hF, f} otherwise, whatever the value of `bsr`.
- R4: The result is the byte read plus one, modulo 256 (8'hFF gives 8'h00).
- R5: The skip-if-zero instruction skips exactly when the result is 8'h00.
- R6: The skip-if-nonzero instruction skips exactly when the result is not 8'h00.
- R7: After acceptance `busy` is high for 3 clocks without a skip, for 7 clocks with a skip when `next_two_word` was 0 at acceptance, and for 11 clocks with a skip when it was 1.
- R8: `squash` is a single-clock pulse in ST_Q4_WRITE of an instruction that skips, and it is never high otherwise.
- R9: Words presented, and changes on `bsr` or `next_two_word`, while `busy` is high have no effect on the current instruction and are not executed.
- R10: After reset `busy`, `squash`, `rf_rd_en` and `rf_wr_en` are low and W is 8'h00.
- R11: Each instruction makes exactly one read, in ST_Q2_READ, and at most one write, two clocks later and to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Instruction word from fetch |
| instr_valid | input | 1 | instr_word holds a word to execute |
| next_two_word | input | 1 | The prefetched next instruction is two words long |
| bsr | input | 4 | Bank-select register value |
| rf_addr | output | 12 | Data-memory address |
| rf_rd_en | output | 1 | Read strobe; data returns one clock later |
| rf_rdata | input | 8 | Read data, registered by the memory |
| rf_wr_en | output | 1 | Write strobe |
| rf_wdata | output | 8 | Write data |
| w_value | output | 8 | Working register contents |
| busy | output | 1 | Executor occupied; fetch must stall |
| squash | output | 1 | Discard the prefetched instruction this clock |

## Verification
The assertions assume a memory with a read latency of exactly one clock. They also assume that a new word is offered only while `busy` is low, so any word presented during an instruction is treated as noise. The bench's memory model follows that one-clock latency. The bench drives `instr_valid` during busy periods only as deliberate noise with random legal words, random bank values and random second-word flags. It lowers `instr_valid` in the clock where `busy` falls, so no word is accepted without being intended.

// File: rtl/iskp_pkg.sv
package iskp_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 6;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = 8;
    localparam int BANK_W  = 4;
    localparam int ADDR_W  = BANK_W + FIELD_W;

    localparam logic [OPC_W-1:0] OPC_INC_SKZ  = 6'b001111;
    localparam logic [OPC_W-1:0] OPC_INC_SKNZ = 6'b010010;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_INC_SKZ,
        OP_INC_SKNZ
    } iskp_op_e;

    typedef enum logic [2:0] {
        ST_Q1_DECODE,
        ST_Q2_READ,
        ST_Q3_CALC,
        ST_Q4_WRITE,
        ST_NOP_FLUSH
    } iskp_state_e;

    typedef struct packed {
        iskp_op_e             kind;
        logic                 to_file;
        logic                 use_bsr;
        logic [FIELD_W-1:0]   field;
    } iskp_dec_t;
endpackage

// File: rtl/iskp_decode.sv
module iskp_decode
    import iskp_pkg::*;
#(
    parameter int IW = INSTR_W
) (
    input  logic [IW-1:0] word_in,
    output iskp_dec_t     dec_out
);
    localparam int OPC_LSB = IW - OPC_W;
    localparam int D_BIT   = OPC_LSB - 1;
    localparam int A_BIT   = OPC_LSB - 2;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc = word_in[IW-1:OPC_LSB];
        dec_out.to_file = word_in[D_BIT];
        dec_out.use_bsr = word_in[A_BIT];
        dec_out.field   = word_in[FIELD_W-1:0];
        unique case (opc)
            OPC_INC_SKZ:  dec_out.kind = OP_INC_SKZ;
            OPC_INC_SKNZ: dec_out.kind = OP_INC_SKNZ;
            default:      dec_out.kind = OP_NONE;
        endcase
    end
endmodule

// File: rtl/iskp_bank_addr.sv
module iskp_bank_addr #(
    parameter int FW = iskp_pkg::FIELD_W,
    parameter int BW = iskp_pkg::BANK_W
) (
    input  logic [FW-1:0]    field,
    input  logic             use_bsr,
    input  logic [BW-1:0]    bsr_val,
    output logic [BW+FW-1:0] addr
);
    localparam logic [BW-1:0] LOW_BANK  = '0;
    localparam logic [BW-1:0] HIGH_BANK = '1;

    logic [BW-1:0] access_bank;

    // upper half of the field selects the top bank of the access window
    assign access_bank = field[FW-1] ? HIGH_BANK : LOW_BANK;

    always_comb begin
        if (use_bsr) begin
            addr = {bsr_val, field};
        end else begin
            addr = {access_bank, field};
        end
    end
endmodule

// File: rtl/iskp_alu.sv
module iskp_alu
    import iskp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] result_q,
    input  iskp_op_e      kind,
    output logic [DW-1:0] sum,
    output logic          skip
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic res_zero;

    assign sum      = operand + ONE;
    assign res_zero = (result_q == '0);

    always_comb begin
        unique case (kind)
            OP_INC_SKZ:  skip = res_zero;
            OP_INC_SKNZ: skip = !res_zero;
            default:     skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/iskp_phase_ctrl.sv
module iskp_phase_ctrl
    import iskp_pkg::*;
#(
    parameter int PHASES      = 4,
    parameter int MAX_NOP_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        skip_now,
    input  logic        two_word_q,
    output iskp_state_e state,
    output logic        busy,
    output logic        rd_phase,
    output logic        calc_phase,
    output logic        wr_phase,
    output logic        squash
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int NC_W = $clog2(MAX_NOP_CYC + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [NC_W-1:0] NC_ONE  = NC_W'(1);
    localparam logic [NC_W-1:0] NC_TWO  = NC_W'(2);

    iskp_state_e     state_q, state_d;
    logic [PH_W-1:0] ph_q, ph_d;
    logic [NC_W-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_Q1_DECODE;
            ph_q    <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            left_q  <= left_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        left_d  = left_q;
        unique case (state_q)
            ST_Q1_DECODE: begin
                if (start) begin
                    state_d = ST_Q2_READ;
                end
            end
            ST_Q2_READ:  state_d = ST_Q3_CALC;
            ST_Q3_CALC:  state_d = ST_Q4_WRITE;
            ST_Q4_WRITE: begin
                if (skip_now) begin
                    state_d = ST_NOP_FLUSH;
                    ph_d    = '0;
                    left_d  = two_word_q ? NC_TWO : NC_ONE;
                end else begin
                    state_d = ST_Q1_DECODE;
                end
            end
            ST_NOP_FLUSH: begin
                if (ph_q == PH_LAST) begin
                    ph_d = '0;
                    if (left_q == NC_ONE) begin
                        state_d = ST_Q1_DECODE;
                        left_d  = '0;
                    end else begin
                        left_d = left_q - NC_ONE;
                    end
                end else begin
                    ph_d = ph_q + PH_W'(1);
                end
            end
            default: state_d = ST_Q1_DECODE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        rd_phase   = 1'b0;
        calc_phase = 1'b0;
        wr_phase   = 1'b0;
        squash     = 1'b0;
        unique case (state_q)
            ST_Q1_DECODE: busy       = 1'b0;
            ST_Q2_READ:   rd_phase   = 1'b1;
            ST_Q3_CALC:   calc_phase = 1'b1;
            ST_Q4_WRITE: begin
                wr_phase = 1'b1;
                squash   = skip_now;
            end
            ST_NOP_FLUSH: busy = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
    import iskp_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int DW = DATA_W,
    parameter int FW = FIELD_W,
    parameter int BW = BANK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   instr_word,
    input  logic            instr_valid,
    input  logic            next_two_word,
    input  logic [BW-1:0]   bsr,
    output logic [BW+FW-1:0] rf_addr,
    output logic            rf_rd_en,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_wr_en,
    output logic [DW-1:0]   rf_wdata,
    output logic [DW-1:0]   w_value,
    output logic            busy,
    output logic            squash
);
    iskp_dec_t   dec_in, dec_q;
    iskp_state_e state;
    logic [BW-1:0] bsr_q;
    logic          two_word_q;
    logic [DW-1:0] sum, result_q, w_q;
    logic          skip_now, start;
    logic          rd_phase, calc_phase, wr_phase;

    iskp_decode #(.IW(IW)) u_decode (
        .word_in (instr_word),
        .dec_out (dec_in)
    );

    assign start = instr_valid && (dec_in.kind != OP_NONE) && (state == ST_Q1_DECODE);

    iskp_bank_addr #(.FW(FW), .BW(BW)) u_addr (
        .field   (dec_q.field),
        .use_bsr (dec_q.use_bsr),
        .bsr_val (bsr_q),
        .addr    (rf_addr)
    );

    iskp_alu #(.DW(DW)) u_alu (
        .operand  (rf_rdata),
        .result_q (result_q),
        .kind     (dec_q.kind),
        .sum      (sum),
        .skip     (skip_now)
    );

    iskp_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .skip_now   (skip_now),
        .two_word_q (two_word_q),
        .state      (state),
        .busy       (busy),
        .rd_phase   (rd_phase),
        .calc_phase (calc_phase),
        .wr_phase   (wr_phase),
        .squash     (squash)
    );

    // decode-phase capture of the word and its context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= '0;
            bsr_q      <= '0;
            two_word_q <= 1'b0;
        end else if (start) begin
            dec_q      <= dec_in;
            bsr_q      <= bsr;
            two_word_q <= next_two_word;
        end
    end

    // compute phase result and working register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            w_q      <= '0;
        end else begin
            if (calc_phase) begin
                result_q <= sum;
            end
            if (wr_phase && !dec_q.to_file) begin
                w_q <= result_q;
            end
        end
    end

    assign rf_rd_en = rd_phase;
    assign rf_wr_en = wr_phase && dec_q.to_file;
    assign rf_wdata = result_q;
    assign w_value  = w_q;
endmodule

// File: rtl/incskip_exec_chk.sv
module incskip_exec_chk #(
    parameter int AW = iskp_pkg::ADDR_W,
    parameter int DW = iskp_pkg::DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          squash,
    input logic          rf_rd_en,
    input logic          rf_wr_en,
    input logic [AW-1:0] rf_addr,
    input logic [DW-1:0] w_value
);
    assert_squash_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> busy);

    assert_squash_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash);

    assert_flush_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> busy);

    assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !rf_rd_en);

    assert_wr_same_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ($past(rf_rd_en, 2) && rf_addr == $past(rf_addr, 2)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rf_rd_en && !rf_wr_en && !squash));

    assert_w_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(w_value));
endmodule

bind incskip_exec incskip_exec_chk #(
    .AW(iskp_pkg::ADDR_W),
    .DW(iskp_pkg::DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .squash   (squash),
    .rf_rd_en (rf_rd_en),
    .rf_wr_en (rf_wr_en),
    .rf_addr  (rf_addr),
    .w_value  (w_value)
);

// File: tb/incskip_exec_bench.sv
`timescale 1ns/1ps
module incskip_exec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = '0;
    logic        instr_valid = 1'b0;
    logic        next_two_word = 1'b0;
    logic [3:0]  bsr = '0;
    logic [11:0] rf_addr;
    logic        rf_rd_en;
    logic [7:0]  rf_rdata = '0;
    logic        rf_wr_en;
    logic [7:0]  rf_wdata;
    logic [7:0]  w_value;
    logic        busy;
    logic        squash;

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [0:4095];

    always #10 clk = ~clk;

    incskip_exec u_incskip_exec (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .instr_valid(instr_valid),
        .next_two_word(next_two_word), .bsr(bsr), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
        .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata), .w_value(w_value),
        .busy(busy), .squash(squash)
    );

    always @(posedge clk) begin
        if (rf_wr_en) mem[rf_addr] <= rf_wdata;
        if (rf_rd_en) rf_rdata <= mem[rf_addr];
    end

    function automatic logic [11:0] exp_addr(input logic a, input logic [7:0] f, input logic [3:0] b);
        if (a) return {b, f};
        return f[7] ? {4'hF, f} : {4'h0, f};
    endfunction

    function automatic logic [15:0] encode(input logic z, input logic d, input logic a, input logic [7:0] f);
        return {(z ? 6'b001111 : 6'b010010), d, a, f};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_instr(input logic z, input logic d, input logic a, input logic [7:0] f,
                             input logic [3:0] b, input logic tw, input bit noise);
        logic [11:0] addr;
        logic [7:0]  old_v, old_w, res, rd_a, wr_a, wr_d;
        bit          skip;
        int          exp_cyc, cyc, rds, wrs, sq;
        addr   = exp_addr(a, f, b);
        old_v  = mem[addr];
        old_w  = w_value;
        res    = old_v + 8'd1;
        skip   = z ? (res == 8'h00) : (res != 8'h00);
        exp_cyc = 3 + (skip ? (tw ? 8 : 4) : 0);
        rd_a = '0; wr_a = '0; wr_d = '0;
        cyc = 0; rds = 0; wrs = 0; sq = 0;
        @(negedge clk);
        instr_word = encode(z, d, a, f);
        instr_valid = 1'b1;
        bsr = b;
        next_two_word = tw;
        @(negedge clk);
        instr_valid = noise;
        if (noise) begin
            instr_word = encode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom));
            bsr = 4'($urandom);
            next_two_word = ~tw;
        end
        while (busy && cyc < 40) begin
            cyc++;
            if (rf_rd_en) begin rds++; rd_a = rf_addr[7:0]; end
            if (rf_rd_en) check(rf_addr == addr, "R3 address", rf_addr, addr);
            if (rf_wr_en) begin wrs++; wr_a = rf_addr[7:0]; wr_d = rf_wdata; end
            if (rf_wr_en) check(rf_addr == addr, "R11 write address", rf_addr, addr);
            if (squash) sq++;
            @(negedge clk);
        end
        instr_valid = 1'b0;
        check(cyc == exp_cyc, skip ? (z ? "R5/R7 busy length" : "R6/R7 busy length") : "R7 busy length",
              cyc, exp_cyc);
        check(sq == (skip ? 1 : 0), "R8 squash count", sq, skip ? 1 : 0);
        check(rds == 1, "R11 read count", rds, 1);
        if (d) begin
            check(wrs == 1, "R11 write count", wrs, 1);
            check(wr_d == res, "R4 written value", wr_d, res);
            check(mem[addr] == res, "R2 memory result", mem[addr], res);
            check(w_value == old_w, "R2 W unchanged", w_value, old_w);
        end else begin
            check(wrs == 0, "R2 no write when d=0", wrs, 0);
            check(w_value == res, "R4 W result", w_value, res);
            check(mem[addr] == old_v, "R2 memory unchanged", mem[addr], old_v);
        end
        if (noise) check(!busy && !rf_rd_en, "R9 noise not executed", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !squash && !rf_rd_en && !rf_wr_en, "R10 idle after reset", busy, 0);
        check(w_value == 8'h00, "R10 W reset", w_value, 0);

        // R1 illegal opcode ignored
        instr_word = 16'h2BFF; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check(!busy && !rf_rd_en, "R1 illegal opcode ignored", busy, 0);
        instr_word = 16'h4C12; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check(!busy && !rf_rd_en, "R1 near-miss opcode ignored", busy, 0);

        // R5 skip on wrap, one and two words; R4 wrap value
        mem[12'h005] = 8'hFF; run_instr(1, 1, 0, 8'h05, 4'h9, 0, 0);
        mem[12'h005] = 8'hFF; run_instr(1, 0, 0, 8'h05, 4'h9, 1, 0);
        mem[12'h710] = 8'h04; run_instr(1, 1, 1, 8'h10, 4'h7, 1, 0);
        // R6 nonzero skip and its exception
        mem[12'hF85] = 8'hFF; run_instr(0, 1, 0, 8'h85, 4'h3, 1, 0);
        mem[12'hF85] = 8'h10; run_instr(0, 0, 0, 8'h85, 4'h3, 1, 0);
        mem[12'h07F] = 8'h20; run_instr(0, 1, 0, 8'h7F, 4'hC, 0, 0);
        // R3 bsr used when a=1
        mem[12'hC80] = 8'hFE; run_instr(1, 1, 1, 8'h80, 4'hC, 0, 0);
        // R9 noise during busy
        mem[12'h280] = 8'hFF; run_instr(1, 1, 1, 8'h80, 4'h2, 0, 1);

        for (int k = 0; k < 300; k++) begin
            logic [7:0] f;
            logic [3:0] b;
            logic       a;
            f = 8'($urandom);
            b = 4'($urandom);
            a = 1'($urandom);
            if ($urandom_range(0, 3) == 0) mem[exp_addr(a, f, b)] = 8'hFF;
            run_instr($urandom_range(0, 1), $urandom_range(0, 1), a, f, b,
                      $urandom_range(0, 1), $urandom_range(0, 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule